// File: doc/BRIEF.md
# SPI Command-Byte Register Slave

This block is an SPI peripheral that takes a one-byte command, decodes it, and then acts on a file of sixteen 8-bit registers. The top two bits of the command select one of four operations: register write, register read, direct chip-select routing, or a reserved code that is ignored. A trigger bit inside the command fires a one-cycle buffer strobe for writes and chip-select commands. A read returns the register value on SDO. If the master keeps clocking, the read then returns a checksum byte.

SCLK, CS_n and SDI are sampled with the system clock through synchronisers. SPI mode 1 is used: the slave samples SDI when SCLK falls and changes SDO when SCLK rises, most significant bit first. SDO comes with its own output-enable, so a pad or an outer level can tri-state it. One register holds sticky error flags, which sources outside the block set. Within a single CS_n low period, several commands can follow one another. Each command is followed by one separator byte, which is either a checksum byte or a dummy byte.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, register 3 reads 0x19, register 6 reads 0x60, and every other register reads 0x00. SDO enable, strobe and chip-select outputs are all low.
- R2: A frame `01T0 aaaa` followed by a data byte stores the data in register aaaa. Register 4 is the exception and follows R7.
- R3: A frame `10xx aaaa` puts register aaaa on SDO, MSB first, during the 8 SCLK periods after the command byte. SDO enable stays low during the command byte and while CS_n is high.
- R4: On a read, a further 8 SCLK periods return (0x9B + command byte + byte received during the data phase + data byte) mod 256.
- R5: A frame `11T0 xccc` selects gpio_cs_o[ccc], one-hot. A value of ccc = 7 selects none. The selection holds until the next such command. The command takes effect only while bit 0 of register 9 is 1, and while that bit is 0 the whole bus reads zero.
- R6: buf_trig_o pulses high for exactly one clock after the command byte of a write or chip-select command whose bit 5 is 1. Reads and reserved commands never pulse it.
- R7: In register 4, a high err_set_i[b] sets bit b. Writing a 1 to bit b clears it. Writing a 0 leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: A reserved frame `00T0 aaaa` plus one byte changes no register, fires no strobe, and leaves SDO disabled.
- R9: After each command's payload, exactly one separator byte is skipped and the byte after it is decoded as a new command. CS_n going high aborts any unfinished command with no effect, and the next byte is a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk_i | input | 1 | SPI serial clock, idle low |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_sdi_i | input | 1 | Serial data from the master |
| spi_sdo_o | output | 1 | Serial data to the master |
| spi_sdo_oe_o | output | 1 | SDO drive enable; when low the pad is high impedance |
| err_set_i | input | 8 | Error-flag set requests for register 4 |
| buf_trig_o | output | 1 | One-cycle buffer trigger strobe |
| gpio_cs_o | output | 7 | One-hot chip-select bus |
| regs_o | output | 128 | All sixteen registers, register n at bits [8n+7:8n] |

## Verification
A write of 1s to the error register and an external flag-set request can land on the same bit in the same clock. The bench provokes this by counting the synchroniser and decode stages after the last SCLK fall of the data byte. It then pulses err_set_i for exactly the cycle in which the write commits. It judges the result by reading the flag back: the flag must still be set, while the flags that were not requested must be cleared. Random write, read, chip-select and reserved frames run against a bench model of the register file, and some of these frames are chained under one CS_n.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    OP_RSV = 2'b00,
    OP_WR  = 2'b01,
    OP_RD  = 2'b10,
    OP_CS  = 2'b11
  } spi_op_e;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_SEP  = 2'd2
  } spi_phase_e;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_n_o,
  output logic sdi_o
);
  localparam int LAST = SYNC_STAGES - 1;

  // each stage carries {sclk, cs_n, sdi}
  logic [2:0] pipe [SYNC_STAGES];
  logic       sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= 3'b010;
      sclk_d <= 1'b0;
    end else begin
      pipe[0] <= {sclk_i, cs_n_i, sdi_i};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_d <= pipe[LAST][2];
    end
  end

  assign sclk_rise_o = pipe[LAST][2] & ~sclk_d;
  assign sclk_fall_o = ~pipe[LAST][2] & sclk_d;
  assign cs_n_o      = pipe[LAST][1];
  assign sdi_o       = pipe[LAST][0];
endmodule

// File: rtl/spi_cmd_regfile.sv
module spi_cmd_regfile #(
  parameter int              DW         = 8,
  parameter int              AW         = 4,
  parameter int              ERR_ADDR   = 4,
  parameter int              CSCFG_ADDR = 9,
  parameter int              BUFT_ADDR  = 3,
  parameter logic [DW-1:0]   BUFT_RST   = 8'h19,
  parameter int              SW_ADDR    = 6,
  parameter logic [DW-1:0]   SW_RST     = 8'h60
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [DW-1:0]          err_set_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [DW-1:0]          rd_data_o,
  output logic                   cs_mode_o,
  output logic [(2**AW)*DW-1:0]  regs_o
);
  localparam int NREG = 2 ** AW;

  // Distinct reset values per entry keep this file in flops, not block RAM.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RV = (i == BUFT_ADDR) ? BUFT_RST :
                                   (i == SW_ADDR)   ? SW_RST   : '0;
    logic [DW-1:0] q;
    logic          hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(i));

    if (i == ERR_ADDR) begin : g_flags
      // write-one-to-clear; a set request in the same cycle wins
      always_ff @(posedge clk) begin
        if (rst) q <= RV;
        else     q <= (q & ~(hit ? wr_data_i : '0)) | err_set_i;
      end

      assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        (err_set_i != '0) |=> ((q & $past(err_set_i)) == $past(err_set_i)));
      assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && err_set_i == '0) |=> ((q & $past(wr_data_i)) == '0));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      q <= RV;
        else if (hit) q <= wr_data_i;
      end
    end

    assign regs_o[i*DW +: DW] = q;
  end

  assign rd_data_o = regs_o[rd_addr_i*DW +: DW];
  assign cs_mode_o = regs_o[CSCFG_ADDR*DW];
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
  import spi_cmd_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            AW       = 4,
  parameter int            NGPIO    = 7,
  parameter logic [DW-1:0] CHK_SEED = 8'h9B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             cs_n_i,
  input  logic             sdi_i,
  input  logic [DW-1:0]    rd_data_i,
  input  logic             cs_mode_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             trig_o,
  output logic [NGPIO-1:0] gpio_cs_o,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int BCW   = $clog2(DW);
  localparam int SEL_W = $clog2(NGPIO + 1);

  logic [BCW-1:0] bit_cnt;
  logic [DW-1:0]  rx, rx_next, cmd_q, rdat_q, tx;
  spi_phase_e     phase;
  spi_op_e        op_q, op_now;
  logic           byte_done, t_bit;
  logic [NGPIO-1:0] sel_q, sel_nxt;

  assign rx_next   = {rx[DW-2:0], sdi_i};
  assign byte_done = sclk_fall_i && !cs_n_i && (bit_cnt == BCW'(DW-1));
  assign op_now    = spi_op_e'(rx_next[DW-1 -: 2]);
  assign t_bit     = rx_next[DW-3];
  assign rd_addr_o = rx_next[AW-1:0];

  always_comb begin
    for (int g = 0; g < NGPIO; g++)
      sel_nxt[g] = (rx_next[SEL_W-1:0] == SEL_W'(g));
  end

  // framing state: cleared whenever CS_n is high
  always_ff @(posedge clk) begin
    if (rst || cs_n_i) begin
      bit_cnt  <= '0;
      rx       <= '0;
      phase    <= PH_CMD;
      op_q     <= OP_RSV;
      cmd_q    <= '0;
      rdat_q   <= '0;
      tx       <= '0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      if (sclk_fall_i) begin
        rx      <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_rise_i && sdo_oe_o) begin
        sdo_o <= tx[DW-1];
        tx    <= {tx[DW-2:0], 1'b0};
      end
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            cmd_q <= rx_next;
            op_q  <= op_now;
            phase <= (op_now == OP_CS) ? PH_SEP : PH_DATA;
            if (op_now == OP_RD) begin
              tx       <= rd_data_i;
              rdat_q   <= rd_data_i;
              sdo_oe_o <= 1'b1;
            end
          end
          PH_DATA: begin
            if (op_q == OP_RD) tx <= CHK_SEED + cmd_q + rx_next + rdat_q;
            phase <= PH_SEP;
          end
          default: begin
            phase    <= PH_CMD;
            sdo_oe_o <= 1'b0;
          end
        endcase
      end
    end
  end

  // pulses and persistent chip-select selection
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      trig_o    <= 1'b0;
      sel_q     <= '0;
      gpio_cs_o <= '0;
    end else begin
      wr_en_o   <= 1'b0;
      trig_o    <= 1'b0;
      gpio_cs_o <= cs_mode_i ? sel_q : '0;
      if (byte_done && phase == PH_CMD) begin
        if (op_now == OP_WR || op_now == OP_CS) trig_o <= t_bit;
        if (op_now == OP_CS && cs_mode_i)       sel_q  <= sel_nxt;
      end
      if (byte_done && phase == PH_DATA && op_q == OP_WR) begin
        wr_en_o   <= 1'b1;
        wr_addr_o <= cmd_q[AW-1:0];
        wr_data_o <= rx_next;
      end
    end
  end

  assert_sdo_idle_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n_i |=> !sdo_oe_o);
  assert_cs_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gpio_cs_o));
  assert_cs_gated_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_mode_i |=> (gpio_cs_o == '0));
  assert_trig_single_R6: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);
  assert_read_no_trig_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_CMD && op_now inside {OP_RD, OP_RSV}) |=> !trig_o);
  assert_rsv_no_write_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_DATA && op_q != OP_WR) |=> !wr_en_o);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int NGPIO       = 7,
  parameter int SYNC_STAGES = 2,
  localparam int NREG       = 2 ** AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 spi_sclk_i,
  input  logic                 spi_cs_n_i,
  input  logic                 spi_sdi_i,
  output logic                 spi_sdo_o,
  output logic                 spi_sdo_oe_o,
  input  logic [DW-1:0]        err_set_i,
  output logic                 buf_trig_o,
  output logic [NGPIO-1:0]     gpio_cs_o,
  output logic [NREG*DW-1:0]   regs_o
);
  logic          sclk_rise, sclk_fall, cs_n_s, sdi_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, cs_mode;

  spi_cmd_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk_i), .cs_n_i(spi_cs_n_i), .sdi_i(spi_sdi_i),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_n_o(cs_n_s), .sdi_o(sdi_s)
  );

  spi_cmd_frame #(.DW(DW), .AW(AW), .NGPIO(NGPIO)) frame_i (
    .clk(clk), .rst(rst),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cs_n_i(cs_n_s), .sdi_i(sdi_s),
    .rd_data_i(rd_data), .cs_mode_i(cs_mode),
    .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .trig_o(buf_trig_o), .gpio_cs_o(gpio_cs_o),
    .sdo_o(spi_sdo_o), .sdo_oe_o(spi_sdo_oe_o)
  );

  spi_cmd_regfile #(.DW(DW), .AW(AW)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .err_set_i(err_set_i), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cs_mode_o(cs_mode), .regs_o(regs_o)
  );
endmodule

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, oe, trig;
  logic [7:0]   err_set = '0;
  logic [6:0]   gpio;
  logic [127:0] regs;

  int n_chk = 0, n_err = 0, trig_cnt = 0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  logic       oeb [8];
  logic [7:0] exp_r [16];
  logic [6:0] exp_sel = '0;

  always #4 clk = ~clk;

  spi_cmd_slave dut_i (
    .clk(clk), .rst(rst), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n), .spi_sdi_i(sdi),
    .spi_sdo_o(sdo), .spi_sdo_oe_o(oe), .err_set_i(err_set),
    .buf_trig_o(trig), .gpio_cs_o(gpio), .regs_o(regs)
  );

  always @(posedge clk) if (!rst && trig) trig_cnt <= trig_cnt + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] csum(input logic [7:0] c, input logic [7:0] r, input logic [7:0] d);
    return 8'h9B + c + r + d;
  endfunction

  function automatic logic [6:0] exp_gpio();
    return exp_r[9][0] ? exp_sel : 7'd0;
  endfunction

  // mode 1 master: change SDI on rise, sample SDO just before fall
  task automatic xfer(input int nbits, input logic [7:0] pmask);
    for (int i = 0; i < 8; i++) begin rxb[i] = '0; oeb[i] = 1'b0; end
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      int by; int bi;
      by = b / 8; bi = 7 - (b % 8);
      sclk = 1'b1; sdi = txb[by][bi];
      repeat (HP) @(negedge clk);
      rxb[by][bi] = sdo;
      if (oe) oeb[by] = 1'b1;
      sclk = 1'b0;
      if (b == nbits - 1 && pmask != 0) begin
        // 2 sync stages + edge register + write register: commit at 4th edge
        repeat (3) @(negedge clk);
        err_set = pmask;
        @(negedge clk);
        err_set = '0;
        repeat (HP - 4) @(negedge clk);
      end else begin
        repeat (HP) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  function automatic void model_wr(input logic [3:0] a, input logic [7:0] d);
    if (a == 4'd4) exp_r[4] = exp_r[4] & ~d;
    else           exp_r[a] = d;
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic t);
    int t0;
    t0 = trig_cnt;
    txb[0] = {2'b01, t, 1'b0, a}; txb[1] = d;
    xfer(16, 8'h00);
    model_wr(a, d);
    check("R2 write lands", regs[a*8 +: 8], exp_r[a]);
    check("R6 write strobe count", trig_cnt - t0, t);
  endtask

  task automatic do_read(input logic [3:0] a);
    int t0;
    t0 = trig_cnt;
    txb[0] = {4'b1000, a}; txb[1] = 8'($urandom); txb[2] = 8'h00;
    xfer(24, 8'h00);
    check("R3 read data", rxb[1], exp_r[a]);
    check("R3 no drive in command byte", oeb[0], 1'b0);
    check("R4 checksum", rxb[2], csum(txb[0], txb[1], exp_r[a]));
    check("R6 read never strobes", trig_cnt - t0, 0);
  endtask

  task automatic do_cs(input logic [2:0] idx, input logic t);
    int t0;
    t0 = trig_cnt;
    txb[0] = {2'b11, t, 2'b00, idx}; txb[1] = 8'h00;
    xfer(16, 8'h00);
    if (exp_r[9][0]) exp_sel = (idx < 7) ? 7'(1 << idx) : 7'd0;
    check("R5 gpio select", gpio, exp_gpio());
    check("R6 cs strobe count", trig_cnt - t0, t);
  endtask

  task automatic do_rsv(input logic [3:0] a, input logic [7:0] d, input logic t);
    int t0;
    t0 = trig_cnt;
    txb[0] = {2'b00, t, 1'b0, a}; txb[1] = d;
    xfer(16, 8'h00);
    check("R8 reserved keeps register", regs[a*8 +: 8], exp_r[a]);
    check("R8 reserved no strobe", trig_cnt - t0, 0);
    check("R8 reserved SDO off", {oeb[0], oeb[1]}, 2'b00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) exp_r[i] = 8'h00;
    exp_r[3] = 8'h19; exp_r[6] = 8'h60;
    repeat (6) @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 16; i++) check("R1 reset value", regs[i*8 +: 8], exp_r[i]);
    check("R1 outputs idle", {oe, trig, gpio}, 9'd0);

    // R3/R4 directed: register 3 read gives 0x19 then 0x37
    txb[0] = 8'h83; txb[1] = 8'h00; txb[2] = 8'h00;
    xfer(24, 8'h00);
    check("R3 reg3 value", rxb[1], 8'h19);
    check("R4 reg3 checksum", rxb[2], 8'h37);
    check("R3 SDO released after CS", oe, 1'b0);

    // R5 with mode off: ignored
    do_cs(3'd2, 1'b1);
    do_write(4'd9, 8'h01, 1'b0);
    do_cs(3'd3, 1'b1);
    check("R5 idx3 onehot", gpio, 7'b0001000);
    do_cs(3'd6, 1'b0);
    do_cs(3'd7, 1'b0);
    check("R5 idx7 none", gpio, 7'd0);
    do_cs(3'd0, 1'b1);
    do_write(4'd9, 8'h00, 1'b1);
    check("R5 mode off clears bus", gpio, 7'd0);

    // R7 flags: set, partial clear, same-cycle set vs clear
    @(negedge clk); err_set = 8'hA5; @(negedge clk); err_set = 8'h00;
    exp_r[4] = 8'hA5;
    do_read(4'd4);
    do_write(4'd4, 8'h0F, 1'b0);
    check("R7 partial clear", regs[39:32], 8'hA0);
    txb[0] = 8'h44; txb[1] = 8'hFF;
    xfer(16, 8'h80);
    check("R7 set wins over clear", regs[39:32], 8'h80);
    exp_r[4] = 8'h80;
    do_write(4'd4, 8'hFF, 1'b0);
    check("R7 all cleared", regs[39:32], 8'h00);

    // R8 reserved
    do_rsv(4'd2, 8'h5A, 1'b1);
    do_rsv(4'd3, 8'hFF, 1'b0);

    // R9 chain: write, separator, read, checksum
    txb[0] = 8'h6B; txb[1] = 8'hC3; txb[2] = 8'h00;
    txb[3] = 8'h8B; txb[4] = 8'h11; txb[5] = 8'h00;
    xfer(48, 8'h00);
    exp_r[11] = 8'hC3;
    check("R9 chained read", rxb[4], 8'hC3);
    check("R9 chained checksum", rxb[5], csum(8'h8B, 8'h11, 8'hC3));
    check("R9 no drive in separator", oeb[2], 1'b0);

    // R9 abort mid data byte: no write, next frame decodes cleanly
    txb[0] = 8'h42; txb[1] = 8'hEE;
    xfer(12, 8'h00);
    check("R9 aborted write ignored", regs[23:16], exp_r[2]);
    do_read(4'd6);

    // random mix against model
    for (int k = 0; k < 40; k++) begin
      int sel;
      sel = int'($urandom % 5);
      case (sel)
        0, 1: do_write(4'($urandom), 8'($urandom), 1'($urandom));
        2:    do_read(4'($urandom));
        3:    do_cs(3'($urandom), 1'($urandom));
        default: do_rsv(4'($urandom), 8'($urandom), 1'($urandom));
      endcase
    end
    for (int i = 0; i < 16; i++) check("R2 final register file", regs[i*8 +: 8], exp_r[i]);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule